// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the test access port of a chip. It takes a test clock, a mode-select line, a serial data input and an active-low asynchronous test reset. A sixteen-state controller follows the standard test-port state graph. A 4-bit instruction register chooses which serial register sits between the data input and the data output. Three registers can be chosen: a 1-bit bypass stage, a fixed 32-bit identification word, or the chip's boundary-cell chain.

The boundary-cell chain and the functional core are outside the block. The chain is reached as an external serial segment: the block gives it the serial input, capture, shift and update strobes, and reads back its serial output. The decoded instruction also drives three mode lines for the rest of the chip:
- drive the outputs from the boundary cells;
- force all output drivers to high impedance;
- capture the device pins into the boundary cells.

The serial output changes on the falling test-clock edge. An enable beside it is high only while a shift is in progress.

Top module: `tap_port`

## Requirements
- R1: The controller samples `tms` on the rising `tck` edge and moves through the standard sixteen states. The states are Test-Logic-Reset, Run-Test/Idle, and Select, Capture, Shift, Exit1, Pause, Exit2 and Update for each of DR and IR. A Pause-DR/Exit2-DR detour in the middle of a data shift loses no bits.
- R2: `tdo` and `tdo_oe` are registered on the falling `tck` edge. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR, and 0 in every other state.
- R3: Capture-IR loads 4'b0001 into the instruction shift stage. An instruction scan therefore returns the bits 1,0,0,0 on `tdo`, least significant bit first.
- R4: A newly shifted instruction takes effect only on the rising `tck` edge that leaves Update-IR. Until then the mode lines and the selected path keep their old values, including in Pause-IR and in Update-IR itself.
- R5: Instruction codes and mode lines:
  - 4'b0000 (external test): `mode_drive`=1 and `mode_capture`=1.
  - 4'b0001 (sample/preload): `mode_capture`=1 only.
  - 4'b0011 (clamp): `mode_drive`=1 only.
  - 4'b0100 (float outputs): `mode_hiz`=1 only.
  - 4'b0010 (identify), 4'b1111 (bypass) and every other code: all three mode lines 0.
- R6: Path selection:
  - 4'b0000 and 4'b0001 put the external segment between `tdi` and `tdo`: `tdo` follows `bsr_so`.
  - 4'b0010 selects the identification register.
  - 4'b1111, 4'b0100 and 4'b0011 select the bypass stage.
- R7: In Capture-DR the bypass stage loads 0. A data scan through it returns 0 first, then `tdi` delayed by one clock.
- R8: In Capture-DR with the identify instruction, the identification register loads 32'h0043_4067. Its fields are revision 0 in bits 31:28, part code 16'h0434 in bits 27:12, maker code 11'h033 in bits 11:1, and bit 0 set to 1. Every register shifts least significant bit first toward `tdo`.
- R9: Either of two events resets the port:
  - `trst_n` low, asynchronously;
  - five rising edges in a row with `tms`=1, from any state.

  After a reset the controller is in Test-Logic-Reset, the current instruction is identify, and all mode lines are 0.
- R10: A code that is not one of the six defined codes behaves exactly like bypass: 1-bit path and no mode line active.
- R11: `bsr_capture`, `bsr_shift` and `bsr_update` pulse only in Capture-DR, Shift-DR and Update-DR respectively, and only while the boundary path is selected. `bsr_si` carries `tdi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Output enable for tdo, high only while shifting |
| bsr_si | output | 1 | Serial input to the external boundary segment |
| bsr_so | input | 1 | Serial output of the external boundary segment |
| bsr_capture | output | 1 | Boundary segment capture strobe |
| bsr_shift | output | 1 | Boundary segment shift strobe |
| bsr_update | output | 1 | Boundary segment update strobe |
| mode_drive | output | 1 | Device outputs taken from the boundary cells |
| mode_hiz | output | 1 | All device output drivers forced to high impedance |
| mode_capture | output | 1 | Boundary cells capture the device pins |

## Verification
Each tck period has two sample points:
- Inputs are applied one nanosecond after the rising edge.
- `tdo` and `tdo_oe` are read one nanosecond after the following falling edge. At that point they hold the bit presented in the current state, before the next rising edge shifts the register.

The mode lines change one rising edge after Update-IR, so they are read in Run-Test/Idle after that edge. They are also read in Pause-IR and in Update-IR to show that nothing has changed yet. A `tms`-driven reset is checked after the fourth and the fifth high edge taken from Shift-DR. An asynchronous `trst_n` reset is checked between clock edges.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        ST_TLR,    ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYP,
        PATH_ID,
        PATH_BSR
    } path_e;

    localparam logic [IR_W-1:0] OP_EXT_TEST = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 4'b0001;
    localparam logic [IR_W-1:0] OP_IDENT    = 4'b0010;
    localparam logic [IR_W-1:0] OP_CLAMP    = 4'b0011;
    localparam logic [IR_W-1:0] OP_FLOAT    = 4'b0100;
    localparam logic [IR_W-1:0] OP_BYPASS   = 4'b1111;

    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 4'b0001;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q,
    output logic       tlr_next,
    output logic       cap_ir,
    output logic       shf_ir,
    output logic       upd_ir,
    output logic       cap_dr,
    output logic       shf_dr,
    output logic       upd_dr
);

    tap_state_e state_d;

    // State register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_TLR;
        else         state_q <= state_d;
    end

    // Transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
            default:   state_d = ST_TLR;
        endcase
    end

    // State-decoded strobes
    always_comb begin
        tlr_next = (state_d == ST_TLR);
        cap_ir   = (state_q == ST_CAP_IR);
        shf_ir   = (state_q == ST_SHF_IR);
        upd_ir   = (state_q == ST_UPD_IR);
        cap_dr   = (state_q == ST_CAP_DR);
        shf_dr   = (state_q == ST_SHF_DR);
        upd_dr   = (state_q == ST_UPD_DR);
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            tlr_next,
    input  logic            cap_ir,
    input  logic            shf_ir,
    input  logic            upd_ir,
    output logic [IR_W-1:0] ir_sr,
    output logic [IR_W-1:0] ir_q,
    output path_e           path,
    output logic            mode_drive,
    output logic            mode_hiz,
    output logic            mode_capture
);

    // Shift stage
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     ir_sr <= IR_CAPTURE_PAT;
        else if (cap_ir) ir_sr <= IR_CAPTURE_PAT;
        else if (shf_ir) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Current instruction
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)       ir_q <= OP_IDENT;
        else if (tlr_next) ir_q <= OP_IDENT;
        else if (upd_ir)   ir_q <= ir_sr;
    end

    // Decode
    always_comb begin
        path         = PATH_BYP;
        mode_drive   = 1'b0;
        mode_hiz     = 1'b0;
        mode_capture = 1'b0;
        unique case (ir_q)
            OP_EXT_TEST: begin
                path         = PATH_BSR;
                mode_drive   = 1'b1;
                mode_capture = 1'b1;
            end
            OP_SAMPLE: begin
                path         = PATH_BSR;
                mode_capture = 1'b1;
            end
            OP_IDENT:  path = PATH_ID;
            OP_CLAMP:  mode_drive = 1'b1;
            OP_FLOAT:  mode_hiz   = 1'b1;
            default:   path = PATH_BYP;
        endcase
    end

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int          ID_W    = 32,
    parameter logic [31:0] ID_WORD = 32'h0043_4067
) (
    input  logic  tck,
    input  logic  trst_n,
    input  logic  tdi,
    input  logic  cap_dr,
    input  logic  shf_dr,
    input  logic  shf_ir,
    input  path_e path,
    input  logic  ir_lsb,
    input  logic  bsr_so,
    output logic  tdo,
    output logic  tdo_oe
);

    logic            byp_q;
    logic [ID_W-1:0] id_sr;
    logic            dr_bit;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
            id_sr <= ID_WORD[ID_W-1:0];
        end else if (cap_dr) begin
            byp_q <= 1'b0;
            if (path == PATH_ID) id_sr <= ID_WORD[ID_W-1:0];
        end else if (shf_dr) begin
            byp_q <= tdi;
            if (path == PATH_ID) id_sr <= {tdi, id_sr[ID_W-1:1]};
        end
    end

    always_comb begin
        unique case (path)
            PATH_ID:  dr_bit = id_sr[0];
            PATH_BSR: dr_bit = bsr_so;
            default:  dr_bit = byp_q;
        endcase
    end

    // Falling-edge output stage
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= shf_ir | shf_dr;
            if (shf_ir)      tdo <= ir_lsb;
            else if (shf_dr) tdo <= dr_bit;
        end
    end

endmodule

// File: rtl/tap_port.sv
module tap_port
    import tap_pkg::*;
#(
    parameter logic [3:0]  ID_REV   = 4'h0,
    parameter logic [15:0] ID_PART  = 16'h0434,
    parameter logic [10:0] ID_MAKER = 11'h033
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe,
    output logic bsr_si,
    input  logic bsr_so,
    output logic bsr_capture,
    output logic bsr_shift,
    output logic bsr_update,
    output logic mode_drive,
    output logic mode_hiz,
    output logic mode_capture
);

    localparam logic [31:0] ID_WORD = {ID_REV, ID_PART, ID_MAKER, 1'b1};

    tap_state_e      st;
    logic            tlr_next, cap_ir, shf_ir, upd_ir, cap_dr, shf_dr, upd_dr;
    logic [IR_W-1:0] ir_sr, ir_q;
    path_e           path;
    logic            sel_bsr;

    tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state_q(st), .tlr_next(tlr_next),
        .cap_ir(cap_ir), .shf_ir(shf_ir), .upd_ir(upd_ir),
        .cap_dr(cap_dr), .shf_dr(shf_dr), .upd_dr(upd_dr)
    );

    tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .tlr_next(tlr_next),
        .cap_ir(cap_ir), .shf_ir(shf_ir), .upd_ir(upd_ir),
        .ir_sr(ir_sr), .ir_q(ir_q), .path(path),
        .mode_drive(mode_drive), .mode_hiz(mode_hiz), .mode_capture(mode_capture)
    );

    tap_dr #(.ID_W(32), .ID_WORD(ID_WORD)) u_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .cap_dr(cap_dr), .shf_dr(shf_dr),
        .shf_ir(shf_ir), .path(path), .ir_lsb(ir_sr[0]), .bsr_so(bsr_so),
        .tdo(tdo), .tdo_oe(tdo_oe)
    );

    assign sel_bsr     = (path == PATH_BSR);
    assign bsr_si      = tdi;
    assign bsr_capture = cap_dr & sel_bsr;
    assign bsr_shift   = shf_dr & sel_bsr;
    assign bsr_update  = upd_dr & sel_bsr;

endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
    import tap_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input tap_state_e      st,
    input logic [IR_W-1:0] ir_sr,
    input logic [IR_W-1:0] ir_q,
    input logic            tdo_oe,
    input logic            mode_drive,
    input logic            mode_hiz,
    input logic            mode_capture,
    input logic            bsr_capture,
    input logic            bsr_update
);

    logic [2:0] tms_run;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)          tms_run <= 3'd0;
        else if (!tms)        tms_run <= 3'd0;
        else if (tms_run != 3'd7) tms_run <= tms_run + 3'd1;
    end

    AST_OE_WHEN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == (st == ST_SHF_DR || st == ST_SHF_IR)); // R2

    AST_IR_CAPTURE_PAT: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(st) == ST_CAP_IR) |-> (ir_sr == IR_CAPTURE_PAT)); // R3

    AST_IR_HELD: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(st) != ST_UPD_IR && st != ST_TLR) |-> $stable(ir_q)); // R4

    AST_HIZ_AFTER_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(mode_hiz) |-> ($past(st) == ST_UPD_IR)); // R5

    AST_TMS_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        (tms_run >= 3'd5) |-> (st == ST_TLR)); // R9

    AST_TLR_MODES_IDLE: assert property (@(posedge tck) disable iff (!trst_n)
        (st == ST_TLR) |-> (!mode_drive && !mode_hiz && !mode_capture)); // R9

    AST_BSR_STROBE_STATE: assert property (@(posedge tck) disable iff (!trst_n)
        (bsr_capture || bsr_update) |-> !tdo_oe); // R11

endmodule

bind tap_port tap_port_chk u_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .st(st), .ir_sr(ir_sr), .ir_q(ir_q),
    .tdo_oe(tdo_oe), .mode_drive(mode_drive), .mode_hiz(mode_hiz),
    .mode_capture(mode_capture), .bsr_capture(bsr_capture), .bsr_update(bsr_update)
);

// File: tb/tb_tap_port.sv
module tb_tap_port;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b1, bsr_so;
    logic tdo, tdo_oe, bsr_si, bsr_capture, bsr_shift, bsr_update;
    logic mode_drive, mode_hiz, mode_capture;

    int checks = 0, errors = 0, oe_err = 0, cap_cnt = 0, upd_cnt = 0;
    logic [7:0] seg = 8'h00;

    localparam logic [31:0] ID_EXP = 32'h0043_4067;
    // {opcode[8:5], drive[4], hiz[3], capture[2], path[1:0]}; path 0 bypass, 1 id, 2 boundary
    localparam logic [8:0] VEC [0:6] = '{
        {4'b0000, 1'b1, 1'b0, 1'b1, 2'd2},
        {4'b0001, 1'b0, 1'b0, 1'b1, 2'd2},
        {4'b0010, 1'b0, 1'b0, 1'b0, 2'd1},
        {4'b0011, 1'b1, 1'b0, 1'b0, 2'd0},
        {4'b0100, 1'b0, 1'b1, 1'b0, 2'd0},
        {4'b1111, 1'b0, 1'b0, 1'b0, 2'd0},
        {4'b0101, 1'b0, 1'b0, 1'b0, 2'd0}
    };

    tap_port dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .bsr_si(bsr_si), .bsr_so(bsr_so), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
        .bsr_update(bsr_update), .mode_drive(mode_drive), .mode_hiz(mode_hiz),
        .mode_capture(mode_capture)
    );

    always #4 tck = ~tck;

    // External boundary segment model
    assign bsr_so = seg[0];
    always @(posedge tck) begin
        if (bsr_capture)    seg <= 8'hA5;
        else if (bsr_shift) seg <= {bsr_si, seg[7:1]};
        if (bsr_capture) cap_cnt++;
        if (bsr_update)  upd_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d, input logic exp_oe, output logic o);
        tms = m; tdi = d;
        @(negedge tck); #1;
        o = tdo;
        if (tdo_oe !== exp_oe) oe_err++;
        @(posedge tck); #1;
    endtask

    task automatic scan_ir(input logic [3:0] op, output logic [3:0] cap);
        logic x;
        tick(1, 0, 0, x); tick(1, 0, 0, x); tick(0, 0, 0, x); tick(0, 0, 0, x);
        for (int i = 0; i < 4; i++) tick(i == 3, op[i], 1, cap[i]);
        tick(1, 0, 0, x); tick(0, 0, 0, x);
    endtask

    task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
        logic x;
        dout = '0;
        tick(1, 0, 0, x); tick(0, 0, 0, x); tick(0, 0, 0, x);
        for (int i = 0; i < n; i++) tick(i == n - 1, din[i], 1, dout[i]);
        tick(1, 0, 0, x); tick(0, 0, 0, x);
    endtask

    initial begin
        #160000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
        $finish;
    end

    initial begin
        logic [3:0] cap;
        logic [31:0] dout;
        logic x;
        repeat (3) @(posedge tck);
        #1;
        chk("R9 reset modes", {29'd0, mode_drive, mode_hiz, mode_capture}, 32'd0);
        chk("R2 reset oe", {31'd0, tdo_oe}, 32'd0);
        trst_n = 1'b1;
        @(posedge tck); #1;
        tick(0, 0, 0, x);                    // to Run-Test/Idle
        scan_dr(32, 32'h0, dout);
        chk("R8 id after reset", dout, ID_EXP);

        // Vector table
        for (int v = 0; v < 7; v++) begin
            logic [8:0] e;
            int c0, u0;
            e = VEC[v];
            scan_ir(e[8:5], cap);
            chk("R3 capture-ir", {28'd0, cap}, 32'h1);
            chk(e[8:5] == 4'b0101 ? "R10 modes" : "R5 modes",
                {29'd0, mode_drive, mode_hiz, mode_capture}, {29'd0, e[4:2]});
            c0 = cap_cnt; u0 = upd_cnt;
            if (e[1:0] == 2'd1) begin
                scan_dr(32, 32'hFFFF_FFFF, dout);
                chk("R8 id word", dout, ID_EXP);
            end else if (e[1:0] == 2'd2) begin
                scan_dr(8, 32'h3C, dout);
                chk("R6 boundary path", dout, 32'hA5);
                chk("R11 bsr_si carries tdi", {24'd0, seg}, 32'h3C);
                chk("R11 strobe counts", {cap_cnt - c0, upd_cnt - u0}, {32'd1, 32'd1});
            end else begin
                scan_dr(8, 32'hB2, dout);
                chk(e[8:5] == 4'b0101 ? "R10 bypass" : "R7 bypass", dout, 32'h64);
                chk("R11 no strobes", {cap_cnt - c0, upd_cnt - u0}, 32'd0);
            end
        end

        // R1: Pause-DR detour during identify scan
        scan_ir(4'b0010, cap);
        tick(1, 0, 0, x); tick(0, 0, 0, x); tick(0, 0, 0, x);
        dout = '0;
        for (int i = 0; i < 16; i++) tick(i == 15, 0, 1, dout[i]);
        tick(0, 0, 0, x); tick(0, 0, 0, x); tick(1, 0, 0, x); tick(0, 0, 0, x);
        for (int i = 16; i < 32; i++) tick(i == 31, 0, 1, dout[i]);
        tick(1, 0, 0, x); tick(0, 0, 0, x);
        chk("R1 pause-dr detour", dout, ID_EXP);

        // R4: instruction held until Update-IR is left
        tick(1, 0, 0, x); tick(1, 0, 0, x); tick(0, 0, 0, x); tick(0, 0, 0, x);
        for (int i = 0; i < 4; i++) tick(i == 3, (i == 2), 1, x);
        tick(0, 0, 0, x);                    // Exit1-IR -> Pause-IR
        chk("R4 pause-ir no change", {31'd0, mode_hiz}, 32'd0);
        tick(1, 0, 0, x);                    // -> Exit2-IR
        tick(1, 0, 0, x);                    // -> Update-IR
        chk("R4 in update-ir no change", {31'd0, mode_hiz}, 32'd0);
        tick(0, 0, 0, x);                    // -> Run-Test/Idle
        chk("R4 after update-ir", {31'd0, mode_hiz}, 32'd1);

        // R9: five tms-high edges from Shift-DR
        tick(1, 0, 0, x); tick(0, 0, 0, x); tick(0, 0, 0, x);
        for (int i = 0; i < 4; i++) tick(1, 0, i == 0, x);
        chk("R9 four tms highs not reset", {31'd0, mode_hiz}, 32'd1);
        tick(1, 0, 0, x);
        chk("R9 five tms highs reset", {29'd0, mode_drive, mode_hiz, mode_capture}, 32'd0);
        tick(0, 0, 0, x);
        scan_dr(32, 32'h0, dout);
        chk("R9 identify after tms reset", dout, ID_EXP);

        // R9: asynchronous trst_n
        scan_ir(4'b0000, cap);
        chk("R5 ext test reloaded", {29'd0, mode_drive, mode_hiz, mode_capture}, 32'h5);
        #1 trst_n = 1'b0;
        #1;
        chk("R9 async trst modes", {29'd0, mode_drive, mode_hiz, mode_capture}, 32'd0);
        @(posedge tck); #1;
        trst_n = 1'b1;
        tick(0, 0, 0, x);
        scan_dr(32, 32'h0, dout);
        chk("R9 identify after trst", dout, ID_EXP);

        chk("R2 oe only while shifting", oe_err, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule